// File: doc/BRIEF.md
# Host Bus Width and Byte-Order Adapter

This block sits between a pseudo-SRAM style host bus (active-low chip select, write enable and output enable, a byte address and a 32-bit data bus) and an internal 32-bit word port that reaches registers and FIFOs. Pins sampled during reset fix the host bus width (8, 16 or 32 bits), the byte order, the polarity of the wait output and whether the host strobes are synchronous to the block clock or asynchronous to it.

Narrow host writes are gathered in a holding word and reach the internal port as a single 32-bit write when the last lane of the word arrives. Narrow host reads fetch a whole internal word on the first lane and serve the remaining lanes from a held copy. Each host access drives the wait output until the returned data is settled, so a host can stretch its strobe on wait alone.

Top module: `hbw_bridge`

## Requirements
- R1: Strap pins are loaded while `rst` is high and held unchanged afterwards. The size strap decodes 00 as 32-bit, 01 as 16-bit, 10 as 8-bit, and the reserved code 11 as 32-bit.
- R2: In 32-bit mode address bits [1:0] are ignored. `int_addr` is `hb_addr[ADDR_W-1:2]`, and each host access makes exactly one internal access.
- R3: In 32-bit mode, with internal byte k at bits [8k+7:8k], the host data is the internal word with 16-bit halves exchanged when order bit 0 is 0, and then bytes exchanged inside each half when order bit 1 is 0. Order 00 reverses all four bytes, 01 swaps bytes inside halves, 10 swaps halves only, and 11 passes the word straight through.
- R4: In 16-bit mode only data[15:0] carry data and bits [31:16] of `hb_dout` read zero. `hb_addr[1]` picks the half (0 = bits [15:0]) and `hb_addr[0]` is ignored. The two bytes are exchanged when order bit 1 is 0. A write reaches the internal port only on half 1, and a read fetches only on half 0.
- R5: In 8-bit mode only data[7:0] carry data and bits [31:8] of `hb_dout` read zero. `hb_addr[1:0]` picks internal byte k and the order strap has no effect. A write reaches the internal port only on byte 3, and a read fetches only on byte 0.
- R6: `hb_wait` is active high when the wait strap is 1 and active low when it is 0. It is inactive when no access is in progress.
- R7: `hb_wait` is active during every host access until the result is settled. Read data on `hb_dout` is valid at least one cycle before `hb_wait` becomes inactive.
- R8: `hb_doe` is high only while both `hb_cs_n` and `hb_oe_n` are low.
- R9: With the async strap at 0, an access is taken on the first rising edge at which chip select and a strobe are low, and wait goes active one cycle after the strobes are driven. With the async strap at 1, the strobes first pass a two-stage synchronizer, and wait goes active three cycles after the strobes are driven.
- R10: `int_req` stays high until the cycle in which `int_ack` is seen and falls on the next cycle. `int_we` gives the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (bus clock in synchronous mode) |
| rst | input | 1 | Synchronous active-high reset; straps are loaded while high |
| strap_size | input | 2 | Host bus width strap |
| strap_order | input | 2 | Byte order strap |
| strap_wait_hi | input | 1 | 1 = wait active high, 0 = active low |
| strap_async | input | 1 | 1 = synchronize host strobes |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_we_n | input | 1 | Host write enable, active low |
| hb_oe_n | input | 1 | Host output enable, active low |
| hb_addr | input | ADDR_W | Host byte address |
| hb_din | input | 32 | Host write data |
| hb_dout | output | 32 | Host read data |
| hb_doe | output | 1 | Enable for the host data drivers |
| hb_wait | output | 1 | Wait indication, polarity from strap |
| int_req | output | 1 | Internal access request |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | ADDR_W-2 | Internal word address |
| int_wdata | output | 32 | Internal write word |
| int_rdata | input | 32 | Internal read word, valid with ack |
| int_ack | input | 1 | Internal access completion |

## Verification
One known word is read under all four order codes. Its bytes are all distinct, so each swap of halves or of bytes inside halves gives a value that no other code produces. Narrow writes go to sequential lanes, and the internal side is checked after each lane, which separates the lane that commits the word from the lanes that only fill the holding word. Paired narrow reads count the internal fetches, which shows whether the second lane comes from the held copy. The sync and async runs are told apart by how many cycles pass before wait goes active, and runs with the other wait polarity and with straps moved after reset show that the reset-time capture governs.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    localparam int WORD_W     = 32;
    localparam int HALF_W     = WORD_W / 2;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        BW_32 = 2'd0,
        BW_16 = 2'd1,
        BW_8  = 2'd2
    } bus_width_e;

    typedef struct packed {
        bus_width_e width;
        logic       swap_bytes;
        logic       swap_halves;
        logic       wait_high;
        logic       async_mode;
    } strap_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_EVAL,
        PH_ISSUE,
        PH_HOLD
    } phase_e;

    function automatic bus_width_e decode_width(input logic [1:0] code);
        case (code)
            2'b01:   return BW_16;
            2'b10:   return BW_8;
            default: return BW_32;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] order_half(input logic [HALF_W-1:0] h,
                                                     input logic sb);
        return sb ? {h[BYTE_W-1:0], h[HALF_W-1:BYTE_W]} : h;
    endfunction

    function automatic logic [WORD_W-1:0] order_word(input logic [WORD_W-1:0] w,
                                                     input logic sb,
                                                     input logic sh);
        logic [WORD_W-1:0] t;
        t = sh ? {w[HALF_W-1:0], w[WORD_W-1:HALF_W]} : w;
        return {order_half(t[WORD_W-1:HALF_W], sb), order_half(t[HALF_W-1:0], sb)};
    endfunction

endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbw_front.sv
module hbw_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_mode,
    input  logic cs_n,
    input  logic we_n,
    input  logic oe_n,
    output logic acc_start,
    output logic acc_write
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw, synced, sel;
    logic            active, active_q;

    assign raw = {cs_n, we_n, oe_n};

    for (genvar i = 0; i < NSIG; i++) begin : g_sync
        hbw_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[i]),
            .q   (synced[i])
        );
    end

    assign sel    = async_mode ? synced : raw;
    assign active = ~sel[2] & (~sel[1] | ~sel[0]);

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end

    assign acc_start = active & ~active_q;
    assign acc_write = ~sel[1];
endmodule

// File: rtl/hbw_lanes.sv
module hbw_lanes
    import hbw_pkg::*;
(
    input  strap_cfg_t        cfg,
    input  logic [1:0]        lane,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [WORD_W-1:0] wbuf,
    input  logic [WORD_W-1:0] rbuf,
    output logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] host_rdata,
    output logic              first_lane,
    output logic              last_lane
);
    always_comb begin
        wr_word    = wbuf;
        host_rdata = '0;
        first_lane = 1'b1;
        last_lane  = 1'b1;
        case (cfg.width)
            BW_16: begin
                first_lane = ~lane[1];
                last_lane  = lane[1];
                if (lane[1]) begin
                    wr_word[WORD_W-1:HALF_W] = order_half(host_wdata[HALF_W-1:0], cfg.swap_bytes);
                    host_rdata[HALF_W-1:0]   = order_half(rbuf[WORD_W-1:HALF_W], cfg.swap_bytes);
                end else begin
                    wr_word[HALF_W-1:0]      = order_half(host_wdata[HALF_W-1:0], cfg.swap_bytes);
                    host_rdata[HALF_W-1:0]   = order_half(rbuf[HALF_W-1:0], cfg.swap_bytes);
                end
            end
            BW_8: begin
                first_lane = (lane == 2'd0);
                last_lane  = (lane == 2'd3);
                wr_word[{lane, 3'b000} +: BYTE_W] = host_wdata[BYTE_W-1:0];
                host_rdata[BYTE_W-1:0]            = rbuf[{lane, 3'b000} +: BYTE_W];
            end
            default: begin
                wr_word    = order_word(host_wdata, cfg.swap_bytes, cfg.swap_halves);
                host_rdata = order_word(rbuf, cfg.swap_bytes, cfg.swap_halves);
            end
        endcase
    end
endmodule

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
    import hbw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc_start,
    input  logic acc_write,
    input  logic first_lane,
    input  logic last_lane,
    input  logic int_ack,
    output logic capture,
    output logic merge_en,
    output logic rbuf_load,
    output logic req,
    output logic is_write,
    output logic busy
);
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            is_write <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (acc_start) begin
                    phase    <= PH_EVAL;
                    is_write <= acc_write;
                end
                PH_EVAL:  phase <= (is_write ? last_lane : first_lane) ? PH_ISSUE : PH_HOLD;
                PH_ISSUE: if (int_ack) phase <= PH_HOLD;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assign capture   = (phase == PH_IDLE) & acc_start;
    assign merge_en  = (phase == PH_EVAL) & is_write;
    assign req       = (phase == PH_ISSUE);
    assign rbuf_load = req & int_ack & ~is_write;
    assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/hbw_bridge.sv
module hbw_bridge
    import hbw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap_size,
    input  logic [1:0]        strap_order,
    input  logic              strap_wait_hi,
    input  logic              strap_async,
    input  logic              hb_cs_n,
    input  logic              hb_we_n,
    input  logic              hb_oe_n,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic [31:0]       hb_din,
    output logic [31:0]       hb_dout,
    output logic              hb_doe,
    output logic              hb_wait,
    output logic              int_req,
    output logic              int_we,
    output logic [ADDR_W-3:0] int_addr,
    output logic [31:0]       int_wdata,
    input  logic [31:0]       int_rdata,
    input  logic              int_ack
);
    strap_cfg_t        cfg;
    logic              acc_start, acc_write;
    logic              capture, merge_en, rbuf_load, busy;
    logic              first_lane, last_lane;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] cur_wdata, wbuf, rbuf, wr_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.width       <= decode_width(strap_size);
            cfg.swap_bytes  <= ~strap_order[1];
            cfg.swap_halves <= ~strap_order[0];
            cfg.wait_high   <= strap_wait_hi;
            cfg.async_mode  <= strap_async;
        end
    end

    hbw_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst        (rst),
        .async_mode (cfg.async_mode),
        .cs_n       (hb_cs_n),
        .we_n       (hb_we_n),
        .oe_n       (hb_oe_n),
        .acc_start  (acc_start),
        .acc_write  (acc_write)
    );

    hbw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .acc_start  (acc_start),
        .acc_write  (acc_write),
        .first_lane (first_lane),
        .last_lane  (last_lane),
        .int_ack    (int_ack),
        .capture    (capture),
        .merge_en   (merge_en),
        .rbuf_load  (rbuf_load),
        .req        (int_req),
        .is_write   (int_we),
        .busy       (busy)
    );

    hbw_lanes u_lanes (
        .cfg        (cfg),
        .lane       (cur_addr[1:0]),
        .host_wdata (cur_wdata),
        .wbuf       (wbuf),
        .rbuf       (rbuf),
        .wr_word    (wr_word),
        .host_rdata (hb_dout),
        .first_lane (first_lane),
        .last_lane  (last_lane)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            cur_wdata <= '0;
            wbuf      <= '0;
            rbuf      <= '0;
        end else begin
            if (capture) begin
                cur_addr  <= hb_addr;
                cur_wdata <= hb_din;
            end
            if (merge_en)  wbuf <= wr_word;
            if (rbuf_load) rbuf <= int_rdata;
        end
    end

    assign int_addr  = cur_addr[ADDR_W-1:2];
    assign int_wdata = wbuf;
    assign hb_doe    = ~hb_cs_n & ~hb_oe_n;
    assign hb_wait   = cfg.wait_high ? busy : ~busy;
endmodule

// File: rtl/hbw_bridge_chk.sv
module hbw_bridge_chk
    import hbw_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input strap_cfg_t  cfg,
    input logic        busy,
    input logic        hb_wait,
    input logic [31:0] hb_dout,
    input logic        int_req,
    input logic        int_ack
);
    // R1
    straps_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ack) |=> int_req);

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_ack) |=> !int_req);

    // R7
    req_waits_chk: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (hb_wait == cfg.wait_high));

    // R7
    rdata_settled_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $stable(hb_dout));
endmodule

bind hbw_bridge hbw_bridge_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .busy    (busy),
    .hb_wait (hb_wait),
    .hb_dout (hb_dout),
    .int_req (int_req),
    .int_ack (int_ack)
);

// File: tb/test_hbw_bridge.sv
module test_hbw_bridge;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    strap_size = 2'b00, strap_order = 2'b11;
    logic          strap_wait_hi = 1'b1, strap_async = 1'b0;
    logic          hb_cs_n = 1'b1, hb_we_n = 1'b1, hb_oe_n = 1'b1;
    logic [AW-1:0] hb_addr = '0;
    logic [31:0]   hb_din = '0;
    logic [31:0]   hb_dout;
    logic          hb_doe, hb_wait;
    logic          int_req, int_we, int_ack = 1'b0;
    logic [AW-3:0] int_addr;
    logic [31:0]   int_wdata, int_rdata = '0;

    logic [31:0] mem [16];
    int          ack_count = 0;
    int          lat_cnt = 0;
    int          checks = 0, errors = 0;
    logic        act_lvl = 1'b1;

    always #2.5 clk = ~clk;

    hbw_bridge #(.ADDR_W(AW)) i_hbw_bridge (
        .clk(clk), .rst(rst), .strap_size(strap_size), .strap_order(strap_order),
        .strap_wait_hi(strap_wait_hi), .strap_async(strap_async),
        .hb_cs_n(hb_cs_n), .hb_we_n(hb_we_n), .hb_oe_n(hb_oe_n),
        .hb_addr(hb_addr), .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe),
        .hb_wait(hb_wait), .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata), .int_ack(int_ack)
    );

    // internal-side model: acknowledges two cycles after a request
    always @(posedge clk) begin
        int_ack <= 1'b0;
        if (int_req && !int_ack) begin
            if (lat_cnt == 1) begin
                lat_cnt   <= 0;
                int_ack   <= 1'b1;
                ack_count <= ack_count + 1;
                int_rdata <= mem[int_addr[3:0]];
                if (int_we) mem[int_addr[3:0]] <= int_wdata;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sz, input logic [1:0] ord,
                            input logic wh, input logic as);
        @(negedge clk);
        rst = 1'b1; strap_size = sz; strap_order = ord;
        strap_wait_hi = wh; strap_async = as; act_lvl = wh;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_access(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                               output logic [31:0] rd, output int reqs,
                               output bit settled, output int lat);
        int          a0;
        bit          seen, done;
        logic [31:0] last;
        a0 = ack_count; seen = 0; done = 0; last = '0; lat = 0;
        @(negedge clk);
        hb_addr = a; hb_din = d; hb_cs_n = 1'b0;
        if (wr) hb_we_n = 1'b0; else hb_oe_n = 1'b0;
        for (int i = 0; i < 60 && !done; i++) begin
            @(negedge clk);
            if (hb_wait == act_lvl) begin
                if (!seen) lat = i + 1;
                seen = 1; last = hb_dout;
            end else if (seen) begin
                done = 1;
            end
        end
        rd = hb_dout;
        settled = done && (last == hb_dout);
        check(done, "R7 access completes", {31'd0, done}, 32'd1);
        hb_cs_n = 1'b1; hb_we_n = 1'b1; hb_oe_n = 1'b1;
        repeat (5) @(negedge clk);
        reqs = ack_count - a0;
    endtask

    task automatic t_reset;
        do_reset(2'b00, 2'b11, 1'b1, 1'b0);
        check(hb_wait == 1'b0, "R6 idle wait high-mode", {31'd0, hb_wait}, 32'd0);
        check(int_req == 1'b0, "R10 no request after reset", {31'd0, int_req}, 32'd0);
        check(hb_doe == 1'b0, "R8 drivers off idle", {31'd0, hb_doe}, 32'd0);
    endtask

    task automatic t_word_orders;
        logic [31:0] rd; int n, lat; bit st;
        logic [31:0] exp [4];
        exp[0] = 32'hD4C3B2A1; exp[1] = 32'hB2A1D4C3;
        exp[2] = 32'hC3D4A1B2; exp[3] = 32'hA1B2C3D4;
        for (int o = 0; o < 4; o++) begin
            do_reset(2'b00, o[1:0], 1'b1, 1'b0);
            host_access(1'b0, 10'h004, '0, rd, n, st, lat);
            check(rd == exp[o], "R3 word order read", rd, exp[o]);
            check(n == 1, "R2 one fetch per word", n, 1);
            check(st, "R7 data settled before release", {31'd0, st}, 32'd1);
        end
        host_access(1'b0, 10'h007, '0, rd, n, st, lat);
        check(rd == 32'hA1B2C3D4, "R2 low address bits ignored", rd, 32'hA1B2C3D4);
        check(lat == 1, "R9 sync wait latency", lat, 1);
        do_reset(2'b00, 2'b00, 1'b1, 1'b0);
        host_access(1'b1, 10'h00B, 32'h11223344, rd, n, st, lat);
        check(mem[2] == 32'h44332211, "R3 big-order write", mem[2], 32'h44332211);
        check(n == 1, "R2 one write per word", n, 1);
    endtask

    task automatic t_half;
        logic [31:0] rd; int n, lat; bit st;
        do_reset(2'b01, 2'b11, 1'b1, 1'b0);
        host_access(1'b1, 10'h015, 32'hFFFF5566, rd, n, st, lat);
        check(n == 0 && mem[5] == 32'h0, "R4 half 0 write held", mem[5], 32'h0);
        host_access(1'b1, 10'h016, 32'h00007788, rd, n, st, lat);
        check(n == 1 && mem[5] == 32'h77885566, "R4 half 1 commits word", mem[5], 32'h77885566);
        host_access(1'b0, 10'h004, '0, rd, n, st, lat);
        check(rd == 32'h0000C3D4 && n == 1, "R4 half 0 read fetches", rd, 32'h0000C3D4);
        host_access(1'b0, 10'h007, '0, rd, n, st, lat);
        check(rd == 32'h0000A1B2 && n == 0, "R4 half 1 read from held word", rd, 32'h0000A1B2);
        do_reset(2'b01, 2'b01, 1'b1, 1'b0);
        host_access(1'b0, 10'h004, '0, rd, n, st, lat);
        check(rd == 32'h0000D4C3, "R4 bytes swapped in half", rd, 32'h0000D4C3);
    endtask

    task automatic t_byte;
        logic [31:0] rd; int n, tot, lat; bit st;
        do_reset(2'b10, 2'b00, 1'b1, 1'b0);
        tot = 0;
        for (int k = 0; k < 3; k++) begin
            host_access(1'b1, 10'h018 + 10'(k), 32'hABABAB00 | 32'(k + 1), rd, n, st, lat);
            tot += n;
        end
        check(tot == 0 && mem[6] == 32'h0, "R5 bytes 0..2 held", mem[6], 32'h0);
        host_access(1'b1, 10'h01B, 32'hABABAB04, rd, n, st, lat);
        check(n == 1 && mem[6] == 32'h04030201, "R5 byte 3 commits word", mem[6], 32'h04030201);
        host_access(1'b0, 10'h004, '0, rd, n, st, lat);
        check(rd == 32'h000000D4 && n == 1, "R5 byte 0 read fetches", rd, 32'h000000D4);
        host_access(1'b0, 10'h006, '0, rd, n, st, lat);
        check(rd == 32'h000000B2 && n == 0, "R5 byte 2 from held word", rd, 32'h000000B2);
    endtask

    task automatic t_straps;
        logic [31:0] rd; int n, lat; bit st;
        do_reset(2'b11, 2'b11, 1'b1, 1'b0);
        host_access(1'b0, 10'h004, '0, rd, n, st, lat);
        check(rd == 32'hA1B2C3D4, "R1 reserved size acts as 32-bit", rd, 32'hA1B2C3D4);
        do_reset(2'b00, 2'b11, 1'b1, 1'b0);
        strap_size = 2'b10; strap_order = 2'b00; strap_wait_hi = 1'b0; strap_async = 1'b1;
        repeat (2) @(negedge clk);
        check(hb_wait == 1'b0, "R1 wait polarity frozen", {31'd0, hb_wait}, 32'd0);
        host_access(1'b0, 10'h004, '0, rd, n, st, lat);
        check(rd == 32'hA1B2C3D4, "R1 straps frozen after reset", rd, 32'hA1B2C3D4);
    endtask

    task automatic t_wait_low;
        logic [31:0] rd; int n, lat; bit st;
        do_reset(2'b00, 2'b11, 1'b0, 1'b0);
        check(hb_wait == 1'b1, "R6 idle wait low-mode", {31'd0, hb_wait}, 32'd1);
        host_access(1'b0, 10'h004, '0, rd, n, st, lat);
        check(rd == 32'hA1B2C3D4 && st, "R6 active-low wait access", rd, 32'hA1B2C3D4);
    endtask

    task automatic t_async;
        logic [31:0] rd; int n, lat; bit st;
        do_reset(2'b00, 2'b11, 1'b1, 1'b1);
        host_access(1'b0, 10'h004, '0, rd, n, st, lat);
        check(rd == 32'hA1B2C3D4, "R9 async read", rd, 32'hA1B2C3D4);
        check(lat == 3, "R9 async wait latency", lat, 3);
        host_access(1'b1, 10'h01C, 32'hCAFEF00D, rd, n, st, lat);
        check(mem[7] == 32'hCAFEF00D && n == 1, "R9 async write", mem[7], 32'hCAFEF00D);
    endtask

    task automatic t_doe;
        do_reset(2'b00, 2'b11, 1'b1, 1'b0);
        @(negedge clk); hb_cs_n = 1'b1; hb_oe_n = 1'b0;
        #1 check(hb_doe == 1'b0, "R8 no drive without select", {31'd0, hb_doe}, 32'd0);
        @(negedge clk); hb_cs_n = 1'b0; hb_oe_n = 1'b1;
        #1 check(hb_doe == 1'b0, "R8 no drive without oe", {31'd0, hb_doe}, 32'd0);
        @(negedge clk); hb_oe_n = 1'b0;
        #1 check(hb_doe == 1'b1, "R8 drive during read", {31'd0, hb_doe}, 32'd1);
        repeat (10) @(negedge clk);
        hb_cs_n = 1'b1; hb_oe_n = 1'b1;
        repeat (5) @(negedge clk);
        check(int_req == 1'b0, "R10 request released", {31'd0, int_req}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        mem[1] = 32'hA1B2C3D4;
        t_reset();
        t_word_orders();
        t_half();
        t_byte();
        t_straps();
        t_wait_low();
        t_async();
        t_doe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #750000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule